// File: doc/BRIEF.md
# Multi-Granule Radix Page-Table Walker

This block resolves a virtual address into a physical page by stepping through a radix page table held in memory. A two-bit granule input chooses among three page sizes, and each page size carries its own table depth, index width and virtual-address width. The 4 KiB granule walks four levels of 9-bit indices over a 48-bit address. The 16 KiB granule walks three levels of 11-bit indices over 47 bits. The 64 KiB granule walks two levels of 13-bit indices over 42 bits. In every granule one table fills exactly one page of 8-byte entries.

A client presents a virtual address and the physical base of the root table. The walker then issues one 64-bit read per level on a simple request/response memory port. Each read address is the current table base plus the level's index times eight, and the first read uses the most significant index field. The walk ends in one of two ways. It can report a physical page number with permission bits on a one-cycle done pulse. It can instead report a one-cycle fault that gives the level where an invalid entry was found, or that flags an address lying outside the granule's range. Only one walk runs at a time.

Top module: `radix_walker`

## Requirements
- R1: After reset, req_ready_o is 1 and done_o, fault_o and mem_req_valid_o are 0.
- R2: With granule 0 (4 KiB), a walk makes 4 reads. The index at level L (0 = first) is va[47-9L : 39-9L], and the read address is base + index*8.
- R3: With granule 1 (16 KiB), a walk makes 3 reads. The index at level L is va[46-11L : 36-11L], and the read address is base + index*8.
- R4: With granule 2 (64 KiB), a walk makes 2 reads. The index at level L is va[41-13L : 29-13L], and the read address is base + index*8.
- R5: Entry layout: bit 0 is valid and bits [4:1] are permissions. Bits [47:off] hold the next table base or the leaf page number, where off is 12, 14 or 16 for granule 0, 1 or 2. The next base is the entry's bits [47:0] with the low off bits cleared.
- R6: A valid entry at the last level ends the walk with done_o high for exactly one cycle. On that cycle ppn_o = entry[47:off] and perm_o = entry[4:1].
- R7: An entry with bit 0 clear, read at level L, ends the walk. On that cycle fault_o = 1, fault_level_o = L and fault_range_o = 0, and no further read is issued.
- R8: If the virtual address has a bit set at or above the granule's width (48, 47 or 42), or if the granule is 3, the request faults on the cycle after acceptance. That fault has fault_range_o = 1 and fault_level_o = 0, and no memory read is issued.
- R9: req_ready_o is low from the acceptance of a walk that issues reads until the cycle of its done or fault. Requests presented while it is low are ignored.
- R10: Each read request is a single-cycle pulse. The granule, address and root are sampled at acceptance, so changes to them during a walk do not alter its reads or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gran_i | input | 2 | Granule select: 0 = 4 KiB, 1 = 16 KiB, 2 = 64 KiB, 3 = reserved |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted when both high |
| req_va_i | input | 64 | Virtual address to translate |
| req_root_i | input | 48 | Physical base of the root table |
| mem_req_valid_o | output | 1 | One-cycle read request |
| mem_req_addr_o | output | 48 | Byte address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Entry read from memory |
| done_o | output | 1 | One-cycle translation complete |
| ppn_o | output | 36 | Physical page number of the leaf |
| perm_o | output | 4 | Permission bits of the leaf |
| fault_o | output | 1 | One-cycle walk fault |
| fault_level_o | output | 2 | Level at which the fault occurred |
| fault_range_o | output | 1 | Fault caused by an out-of-range address or reserved granule |

## Verification
Directed cases cover addresses of all ones and all zeros that are just inside each granule's width, and addresses with only the first bit above that width set. They also cover the reserved granule. A walker with a wrong width bound would either read memory for an illegal address or reject a legal one. Invalid entries are planted at every level of every granule. This catches a design that reports the wrong fault level or keeps reading after an invalid entry. Other cases present new requests and change the granule in the middle of a walk, which exposes a walker that samples its inputs live or accepts a second walk. Random walks with random response latency compare every read address and the final page number against a model in the bench, which catches a wrong index slice or base masking in any granule.

// File: rtl/walk_pkg.sv
package walk_pkg;
    localparam int VA_W  = 64;
    localparam int PTE_W = 64;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } wstate_e;
endpackage

// File: rtl/walk_index.sv
// Entry address for one level of the walk: table base plus the granule's
// index field at that level, scaled by the entry size.
module walk_index
    import walk_pkg::*;
#(
    parameter int PA_W    = 48,
    parameter int MIN_OFF = 12,
    parameter int STEP    = 2,
    parameter int MAX_LVL = 4,
    parameter int PTE_SH  = 3,
    localparam int LVL_W  = $clog2(MAX_LVL)
) (
    input  logic [1:0]       gran_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic [VA_W-1:0]  va_i,
    input  logic [PA_W-1:0]  base_i,
    output logic [PA_W-1:0]  addr_o
);
    int        off_b;
    int        idx_b;
    int        n_lvl;
    int        shamt;
    logic [VA_W-1:0] idx;

    always_comb begin
        off_b  = MIN_OFF + STEP * int'(gran_i);
        idx_b  = off_b - PTE_SH;
        n_lvl  = MAX_LVL - int'(gran_i);
        shamt  = off_b + idx_b * (n_lvl - 1 - int'(lvl_i));
        if (shamt < 0) shamt = 0;
        idx    = (va_i >> shamt) & ((64'd1 << idx_b) - 64'd1);
        addr_o = base_i + PA_W'(idx << PTE_SH);
    end
endmodule

// File: rtl/walk_range.sv
// Flags an address with bits at or above the granule's width, or the
// reserved granule code.
module walk_range
    import walk_pkg::*;
#(
    parameter int MIN_OFF = 12,
    parameter int STEP    = 2,
    parameter int MAX_LVL = 4,
    parameter int PTE_SH  = 3
) (
    input  logic [1:0]      gran_i,
    input  logic [VA_W-1:0] va_i,
    output logic            bad_o
);
    int off_b;
    int span;

    always_comb begin
        off_b = MIN_OFF + STEP * int'(gran_i);
        span  = off_b + (off_b - PTE_SH) * (MAX_LVL - int'(gran_i));
        if (gran_i == 2'd3) bad_o = 1'b1;
        else                bad_o = (va_i >> span) != '0;
    end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
    import walk_pkg::*;
#(
    parameter int PA_W    = 48,
    parameter int PERM_W  = 4,
    parameter int MIN_OFF = 12,
    parameter int STEP    = 2,
    parameter int MAX_LVL = 4,
    parameter int PTE_SH  = 3,
    localparam int PPN_W  = PA_W - MIN_OFF,
    localparam int LVL_W  = $clog2(MAX_LVL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        gran_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [VA_W-1:0]   req_va_i,
    input  logic [PA_W-1:0]   req_root_i,
    output logic              mem_req_valid_o,
    output logic [PA_W-1:0]   mem_req_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [PTE_W-1:0]  mem_rsp_data_i,
    output logic              done_o,
    output logic [PPN_W-1:0]  ppn_o,
    output logic [PERM_W-1:0] perm_o,
    output logic              fault_o,
    output logic [LVL_W-1:0]  fault_level_o,
    output logic              fault_range_o
);
    typedef struct packed {
        wstate_e           st;
        logic [1:0]        gran;
        logic [VA_W-1:0]   va;
        logic [PA_W-1:0]   base;
        logic [LVL_W-1:0]  lvl;
        logic              done;
        logic              fault;
        logic              rng;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
    } ctx_t;

    ctx_t q, d;

    logic            va_bad;
    logic [PA_W-1:0] entry_addr;
    logic [PA_W-1:0] rsp_pa;
    logic [PA_W-1:0] page_mask;
    int              cur_off;
    int              last_lvl;
    logic            unused_bits;

    assign rsp_pa      = mem_rsp_data_i[PA_W-1:0];
    assign unused_bits = ^{mem_rsp_data_i[PTE_W-1:PA_W],
                           mem_rsp_data_i[MIN_OFF-1:PERM_W+1]};

    walk_range #(
        .MIN_OFF(MIN_OFF), .STEP(STEP), .MAX_LVL(MAX_LVL), .PTE_SH(PTE_SH)
    ) u_range (
        .gran_i (gran_i),
        .va_i   (req_va_i),
        .bad_o  (va_bad)
    );

    walk_index #(
        .PA_W(PA_W), .MIN_OFF(MIN_OFF), .STEP(STEP),
        .MAX_LVL(MAX_LVL), .PTE_SH(PTE_SH)
    ) u_index (
        .gran_i (q.gran),
        .lvl_i  (q.lvl),
        .va_i   (q.va),
        .base_i (q.base),
        .addr_o (entry_addr)
    );

    always_comb begin
        cur_off   = MIN_OFF + STEP * int'(q.gran);
        last_lvl  = MAX_LVL - 1 - int'(q.gran);
        page_mask = (PA_W'(1) << cur_off) - PA_W'(1);

        d       = q;
        d.done  = 1'b0;
        d.fault = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    d.gran = gran_i;
                    d.va   = req_va_i;
                    d.base = req_root_i;
                    d.lvl  = '0;
                    d.rng  = 1'b0;
                    if (va_bad) begin
                        d.fault = 1'b1;
                        d.rng   = 1'b1;
                    end else begin
                        d.st = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_rsp_valid_i) begin
                    if (!mem_rsp_data_i[0]) begin
                        d.fault = 1'b1;
                        d.st    = ST_IDLE;
                    end else if (int'(q.lvl) == last_lvl) begin
                        d.done = 1'b1;
                        d.ppn  = PPN_W'(rsp_pa >> cur_off);
                        d.perm = mem_rsp_data_i[PERM_W:1];
                        d.st   = ST_IDLE;
                    end else begin
                        d.base = rsp_pa & ~page_mask;
                        d.lvl  = q.lvl + LVL_W'(1);
                        d.st   = ST_ISSUE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready_o     = (q.st == ST_IDLE);
    assign mem_req_valid_o = (q.st == ST_ISSUE);
    assign mem_req_addr_o  = entry_addr;
    assign done_o          = q.done;
    assign ppn_o           = q.ppn;
    assign perm_o          = q.perm;
    assign fault_o         = q.fault;
    assign fault_level_o   = q.lvl;
    assign fault_range_o   = q.rng;

    // R9: no read while the walker advertises itself idle
    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> !req_ready_o);

    // R10: read request lasts one cycle
    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |=> !mem_req_valid_o);

    // R6: done is a single-cycle pulse and never coincides with a fault
    p_done_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fault_o));

    // R2: entry addresses are 8-byte aligned when the base is
    p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && q.base[PTE_SH-1:0] == '0) |-> mem_req_addr_o[PTE_SH-1:0] == '0);

    // R8: range faults report level zero and issue no read
    p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && fault_range_o) |-> (fault_level_o == '0 && !mem_req_valid_o));

    // R7: an invalid entry ends the walk with a non-range fault
    p_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT && mem_rsp_valid_i && !mem_rsp_data_i[0])
        |=> (fault_o && !fault_range_o && !mem_req_valid_o));
endmodule

// File: tb/radix_walker_test.sv
module radix_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  gran_i = '0;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [63:0] req_va_i = '0;
    logic [47:0] req_root_i = '0;
    logic        mem_req_valid_o;
    logic [47:0] mem_req_addr_o;
    logic        mem_rsp_valid_i = 1'b0;
    logic [63:0] mem_rsp_data_i = '0;
    logic        done_o;
    logic [35:0] ppn_o;
    logic [3:0]  perm_o;
    logic        fault_o;
    logic [1:0]  fault_level_o;
    logic        fault_range_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit over   = 0;
    logic [63:0] salt = 64'h5A17_C0DE_0F0F_1234;

    radix_walker uut (.*);

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory content model: deterministic entry per address
    function automatic logic [63:0] pte(input logic [47:0] a);
        logic [63:0] h;
        h = (64'(a) * 64'h9E37_79B9_7F4A_7C15) ^ salt;
        return (h & 64'h0000_FFFF_FFFF_F000) | {59'd0, h[4:1], 1'b1};
    endfunction

    function automatic int span_of(input logic [1:0] g);
        int o = 12 + 2 * int'(g);
        return o + (o - 3) * (4 - int'(g));
    endfunction

    // one walk; kill = level whose entry is made invalid (>= levels: none)
    task automatic walk(input logic [1:0] g, input logic [63:0] va,
                        input logic [47:0] root, input int kill, input bit poke);
        int off, ib, nl, nrd, shamt;
        bit bad, fin, exp_fault;
        logic [47:0] base, ea;
        logic [63:0] e, exp_ppn, exp_perm;
        int exp_lvl;
        string tg;
        off = 12 + 2 * int'(g); ib = off - 3; nl = 4 - int'(g);
        bad = (g == 2'd3) || ((va >> span_of(g)) != 0);
        tg  = (g == 0) ? "R2" : (g == 1) ? "R3" : "R4";
        base = root; nrd = 0; fin = 0; exp_fault = bad; exp_lvl = 0;
        exp_ppn = 0; exp_perm = 0;
        @(negedge clk);
        gran_i = g; req_va_i = va; req_root_i = root; req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        for (int c = 0; c < 80 && !fin; c++) begin
            if (mem_req_valid_o) begin
                chk(!bad, "R8 read on bad address", 1, 0);
                chk(!req_ready_o, "R9 ready low during walk", req_ready_o, 0);
                shamt = off + ib * (nl - 1 - nrd);
                ea = base + 48'(((va >> shamt) & ((64'd1 << ib) - 1)) << 3);
                chk(mem_req_addr_o == ea, tg, mem_req_addr_o, ea);
                e = pte(mem_req_addr_o);
                if (nrd == kill) e[0] = 1'b0;
                if (poke) begin
                    req_valid_i = 1'b1; req_va_i = ~va; gran_i = g + 2'd1;
                    req_root_i = ~root;
                end
                @(negedge clk);
                chk(!mem_req_valid_o, "R10 read pulse", mem_req_valid_o, 0);
                repeat ($urandom_range(0, 3)) @(negedge clk);
                req_valid_i = 1'b0;
                mem_rsp_valid_i = 1'b1; mem_rsp_data_i = e;
                if (!e[0]) begin exp_fault = 1; exp_lvl = nrd; end
                else if (nrd == nl - 1) begin
                    exp_ppn = 64'(e[47:0] >> off); exp_perm = 64'(e[4:1]);
                end else begin
                    base = e[47:0] & ~((48'd1 << off) - 1);
                end
                nrd++;
                @(negedge clk);
                mem_rsp_valid_i = 1'b0;
                mem_rsp_data_i = '0;
            end else if (done_o || fault_o) begin
                fin = 1;
                if (exp_fault) begin
                    chk(fault_o && !done_o, "R7 fault expected", {fault_o, done_o}, 2);
                    chk(fault_level_o == 2'(exp_lvl), bad ? "R8 level" : "R7 level",
                        fault_level_o, exp_lvl);
                    chk(fault_range_o == bad, bad ? "R8 range flag" : "R7 range flag",
                        fault_range_o, bad);
                    chk(nrd == (bad ? 0 : exp_lvl + 1), "R7 read count", nrd,
                        bad ? 0 : exp_lvl + 1);
                end else begin
                    chk(done_o && !fault_o, "R6 done expected", {fault_o, done_o}, 1);
                    chk(64'(ppn_o) == exp_ppn, "R6 ppn R5", ppn_o, exp_ppn);
                    chk(64'(perm_o) == exp_perm, "R6 perm R5", perm_o, exp_perm);
                    chk(nrd == nl, {tg, " level count"}, nrd, nl);
                end
                chk(req_ready_o, "R9 ready at end", req_ready_o, 1);
                @(negedge clk);
                chk(!done_o && !fault_o, "R6 one-cycle end pulse", {done_o, fault_o}, 0);
            end else begin
                if (!bad && nrd > 0)
                    chk(!req_ready_o, "R9 ready low while waiting", req_ready_o, 0);
                @(negedge clk);
            end
        end
        if (!fin) chk(0, "R9 walk never ended", 0, 1);
        gran_i = g;
    endtask

    function automatic logic [63:0] rnd_va(input logic [1:0] g);
        logic [63:0] v = {$urandom(), $urandom()};
        return v & ((64'd1 << span_of(g)) - 1);
    endfunction

    initial begin
        wait (cyc > 150000);
        over = 1;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(req_ready_o == 1'b1, "R1 ready after reset", req_ready_o, 1);
        chk(!done_o && !fault_o && !mem_req_valid_o, "R1 outputs idle",
            {done_o, fault_o, mem_req_valid_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready_o && !mem_req_valid_o, "R1 idle after release",
            {req_ready_o, mem_req_valid_o}, 2);

        for (int g = 0; g < 3; g++) begin
            walk(2'(g), (64'd1 << span_of(2'(g))) - 1, 48'h0000_1234_5000, 9, 0);
            walk(2'(g), 64'd0, 48'h0000_0000_0000, 9, 0);
            walk(2'(g), 64'd1 << span_of(2'(g)), 48'h1000, 9, 0);
            walk(2'(g), 64'h8000_0000_0000_0000, 48'h1000, 9, 0);
            for (int k = 0; k < 4 - g; k++)
                walk(2'(g), rnd_va(2'(g)), 48'h0000_00AB_C000, k, 0);
            walk(2'(g), rnd_va(2'(g)), 48'h0000_0042_0000, 9, 1);
        end
        walk(2'd3, 64'd5, 48'h1000, 9, 0);

        for (int i = 0; i < 150 && !over; i++) begin
            logic [1:0]  g;
            logic [63:0] va;
            int kill;
            g  = ($urandom_range(0, 15) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
            va = rnd_va(g);
            if ($urandom_range(0, 9) == 0) va[$urandom_range(span_of(g), 63)] = 1'b1;
            kill = ($urandom_range(0, 9) < 3) ? $urandom_range(0, 3) : 9;
            walk(g, va, {$urandom(), 16'h0} & 48'hFFFF_FFFF_F000, kill,
                 $urandom_range(0, 7) == 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule